// File: doc/BRIEF.md
# Command-Pointer GPIO Register Bank

This block is the register side of an 8-bit I/O expander that sits behind a byte-level bus target. A separate bit-level engine handles the serial protocol and the address match. It hands this block a transfer-start pulse with a read/write flag, each received byte, a request for each byte to transmit, and a stop pulse. In a write transfer the first byte is a command byte. Its low two bits select one of four registers, and every later byte of the same transfer is written to that register. In a read transfer each request returns the currently selected register. The pointer survives between transfers, so a read issued without a fresh command byte re-reads the register last selected.

The four registers are a live input view, an output latch, a per-bit read-inversion mask and a direction mask. The direction mask drives eight tri-state pins through separate value and enable outputs. The input view is built from the pin levels after a two-flop synchronizer and is XORed with the inversion mask when it is read. It reflects every pin whatever its direction, so a driven pin reads back its own level.

A four-state controller sequences the transfer. The states are IDLE, CMD (waiting for the command byte), WDATA (writing data bytes) and RDATA (supplying read bytes). The transitions are:
- IDLE→CMD and IDLE→RDATA on a start pulse, chosen by the read flag.
- CMD→WDATA when the command byte arrives.
- WDATA→WDATA and RDATA→RDATA for each further byte.
- Any state→CMD or RDATA on a repeated start.
- Any state→IDLE on stop.

Stop takes priority over start, and start takes priority over byte activity in the same cycle.

Top module: `gpx_bank`

## Requirements
- R1: After reset the output latch is 0xFF, the inversion mask is 0x00, the direction mask is 0xFF (pin_oe = 0x00, pin_out = 0xFF) and the pointer is 0, so a read with no command returns the input view.
- R2: In a write transfer the first byte loads the pointer from its bits [1:0] (0 input view, 1 output latch, 2 inversion mask, 3 direction mask); bits [7:2] are ignored.
- R3: Every byte after the command byte in one transfer targets the same register, and so does every read in one transfer; the pointer never auto-increments.
- R4: A data byte written while the pointer is 0 changes no register.
- R5: A read transfer returns the register selected by the last command byte, including one given in an earlier transfer.
- R6: Reading pointer 0 returns the synchronized pin levels XOR the inversion mask.
- R7: The input view shows the pin level for every bit, whether the bit is an input or is driven.
- R8: pin_oe[i] is the inverse of direction bit i (1 = input, high impedance), and pin_out equals the output latch.
- R9: A read request registered at the second rising edge after a pin change returns the old level; one registered at the third edge or later returns the new level.
- R10: tx_valid rises for exactly one cycle after each tx_req sampled in RDATA, carrying tx_byte; tx_req in any other state yields no tx_valid.
- R11: Bytes arriving outside a transfer (IDLE) change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start | input | 1 | Pulse: transfer (or repeated start) addressed to this block |
| txn_is_read | input | 1 | Qualifies txn_start: 1 read, 0 write |
| txn_stop | input | 1 | Pulse: transfer ended |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Request for the next byte to transmit |
| tx_valid | output | 1 | tx_byte holds the requested byte |
| tx_byte | output | 8 | Byte to transmit |
| pin_in | input | 8 | Pin levels (asynchronous) |
| pin_out | output | 8 | Pin drive values |
| pin_oe | output | 8 | Pin drive enables, 1 = driven |

## Verification
A read capture and the last synchronizer stage can update on the same edge. The bench provokes this by changing an input pin one cycle before a read request inside an open read transfer. It expects the request at that coinciding edge to return the old level and the next request to return the new one. A second overlap arises on driven pins: a latch write changes pin_out, which loops back through the board wiring into the input view. The bench judges this by reading pointer 0 only after the synchronizer has settled, and comparing against its own model of the resolved pin levels.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam int unsigned SEL_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CMD   = 2'd1,
        ST_WDATA = 2'd2,
        ST_RDATA = 2'd3
    } gpx_state_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_INPUT    = 2'd0,
        SEL_OUTPUT   = 2'd1,
        SEL_POLARITY = 2'd2,
        SEL_CONFIG   = 2'd3
    } gpx_sel_e;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
    import gpx_pkg::*;
#(
    parameter int unsigned      WIDTH   = 8,
    parameter logic [WIDTH-1:0] OUT_RST = '1,
    parameter logic [WIDTH-1:0] POL_RST = '0,
    parameter logic [WIDTH-1:0] CFG_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  gpx_sel_e         wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] out_q,
    output logic [WIDTH-1:0] pol_q,
    output logic [WIDTH-1:0] cfg_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= OUT_RST;
            pol_q <= POL_RST;
            cfg_q <= CFG_RST;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_OUTPUT:   out_q <= wr_data;
                SEL_POLARITY: pol_q <= wr_data;
                SEL_CONFIG:   cfg_q <= wr_data;
                SEL_INPUT:    ; // read-only view: byte dropped
            endcase
        end
    end

    p_input_write_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_INPUT) |=> $stable({out_q, pol_q, cfg_q}));

    p_no_write_no_change_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable({out_q, pol_q, cfg_q}));
endmodule

// File: rtl/gpx_ctrl.sv
module gpx_ctrl
    import gpx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       txn_start,
    input  logic       txn_is_read,
    input  logic       txn_stop,
    input  logic       rx_valid,
    input  logic [1:0] rx_sel,
    input  logic       tx_req,
    output gpx_sel_e   sel_o,
    output logic       wr_en_o,
    output logic       rd_take_o
);
    gpx_state_e state_q, state_d;
    gpx_sel_e   ptr_q;
    logic       ptr_ld;
    logic       quiet;

    assign quiet = !txn_stop && !txn_start;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (txn_stop) begin
            state_d = ST_IDLE;
        end else if (txn_start) begin
            state_d = txn_is_read ? ST_RDATA : ST_CMD;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_CMD:   if (rx_valid) state_d = ST_WDATA;
                ST_WDATA: state_d = ST_WDATA;
                ST_RDATA: state_d = ST_RDATA;
            endcase
        end
    end

    // outputs
    always_comb begin
        ptr_ld    = 1'b0;
        wr_en_o   = 1'b0;
        rd_take_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_CMD:   ptr_ld    = rx_valid && quiet;
            ST_WDATA: wr_en_o   = rx_valid && quiet;
            ST_RDATA: rd_take_o = tx_req && quiet;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      ptr_q <= SEL_INPUT;
        else if (ptr_ld) ptr_q <= gpx_sel_e'(rx_sel);
    end

    assign sel_o = ptr_q;

    p_ptr_only_on_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_q == ST_CMD && rx_valid) |=> $stable(ptr_q));

    p_no_autoinc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WDATA || state_q == ST_RDATA) |=> $stable(ptr_q));

    p_idle_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !wr_en_o);
endmodule

// File: rtl/gpx_bank.sv
module gpx_bank
    import gpx_pkg::*;
#(
    parameter int unsigned      WIDTH       = 8,
    parameter int unsigned      SYNC_STAGES = 2,
    parameter logic [WIDTH-1:0] OUT_RST     = '1,
    parameter logic [WIDTH-1:0] POL_RST     = '0,
    parameter logic [WIDTH-1:0] CFG_RST     = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             txn_start,
    input  logic             txn_is_read,
    input  logic             txn_stop,
    input  logic             rx_valid,
    input  logic [WIDTH-1:0] rx_byte,
    input  logic             tx_req,
    output logic             tx_valid,
    output logic [WIDTH-1:0] tx_byte,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe
);
    gpx_sel_e         sel;
    logic             wr_en, rd_take;
    logic [WIDTH-1:0] out_q, pol_q, cfg_q, pin_sync, rd_mux;

    gpx_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .txn_start   (txn_start),
        .txn_is_read (txn_is_read),
        .txn_stop    (txn_stop),
        .rx_valid    (rx_valid),
        .rx_sel      (rx_byte[SEL_W-1:0]),
        .tx_req      (tx_req),
        .sel_o       (sel),
        .wr_en_o     (wr_en),
        .rd_take_o   (rd_take)
    );

    gpx_regs #(
        .WIDTH   (WIDTH),
        .OUT_RST (OUT_RST),
        .POL_RST (POL_RST),
        .CFG_RST (CFG_RST)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (sel),
        .wr_data (rx_byte),
        .out_q   (out_q),
        .pol_q   (pol_q),
        .cfg_q   (cfg_q)
    );

    gpx_sync #(
        .WIDTH  (WIDTH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .q_sync  (pin_sync)
    );

    always_comb begin
        unique case (sel)
            SEL_INPUT:    rd_mux = pin_sync ^ pol_q;
            SEL_OUTPUT:   rd_mux = out_q;
            SEL_POLARITY: rd_mux = pol_q;
            SEL_CONFIG:   rd_mux = cfg_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else begin
            tx_valid <= rd_take;
            if (rd_take) tx_byte <= rd_mux;
        end
    end

    assign pin_out = out_q;
    assign pin_oe  = ~cfg_q;

    p_txvalid_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(tx_req));

    p_txvalid_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !$past(tx_req, 2)) |=> !tx_valid || $past(tx_req));
endmodule

// File: tb/gpx_bank_tb_top.sv
module gpx_bank_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txn_start = 1'b0, txn_is_read = 1'b0, txn_stop = 1'b0;
    logic       rx_valid = 1'b0, tx_req = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_valid;
    logic [7:0] tx_byte, pin_out, pin_oe, pin_in;
    logic [7:0] ext = 8'hA5;

    int checks = 0, failures = 0;

    // bench model
    logic [7:0] m_out = 8'hFF, m_pol = 8'h00, m_cfg = 8'hFF;
    logic [1:0] m_ptr = 2'd0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    // board wiring: driven pins read back their own value
    assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

    gpx_bank dut_i (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_is_read(txn_is_read),
        .txn_stop(txn_stop), .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_req(tx_req),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read();
        logic [7:0] lvl;
        lvl = (m_cfg & ext) | (~m_cfg & m_out);
        case (m_ptr)
            2'd0: return lvl ^ m_pol;
            2'd1: return m_out;
            2'd2: return m_pol;
            default: return m_cfg;
        endcase
    endfunction

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && tx_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R10 actual=tx_valid expected=none");
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (tx_byte !== e) begin
                    failures++;
                    $display("FAIL %s actual=%02h expected=%02h", t, tx_byte, e);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_txn(input logic rd);
        @(negedge clk);
        txn_start = 1'b1; txn_is_read = rd;
        @(negedge clk);
        txn_start = 1'b0;
    endtask

    task automatic stop_txn();
        txn_stop = 1'b1;
        @(negedge clk);
        txn_stop = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // write transfer: command byte then n data bytes (all same register)
    task automatic write_txn(input logic [7:0] cmd, input logic [7:0] d0,
                             input logic [7:0] d1, input int n);
        start_txn(1'b0);
        send_byte(cmd);
        m_ptr = cmd[1:0];
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = (i == 0) ? d0 : d1;
            send_byte(d);
            case (m_ptr)
                2'd1: m_out = d;
                2'd2: m_pol = d;
                2'd3: m_cfg = d;
                default: ;
            endcase
        end
        stop_txn();
        idle(4);
    endtask

    task automatic req_byte(input string tag, input logic [7:0] e);
        exp_q.push_back(e); tag_q.push_back(tag);
        tx_req = 1'b1;
        @(negedge clk);
        tx_req = 1'b0;
    endtask

    task automatic read_txn(input string tag, input int n);
        start_txn(1'b1);
        for (int i = 0; i < n; i++) req_byte(tag, model_read());
        idle(1);
        stop_txn();
        idle(2);
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(4);
        // R1 reset state at the pins and through reads
        check("R1 pin_oe", pin_oe, 8'h00);
        check("R1 pin_out", pin_out, 8'hFF);
        check("R1 tx_valid", {7'b0, tx_valid}, 8'h00);
        read_txn("R1 R6 ptr0 default", 1);
        write_txn(8'h01, 8'h00, 8'h00, 0); read_txn("R1 out default", 1);
        write_txn(8'h02, 8'h00, 8'h00, 0); read_txn("R1 pol default", 1);
        write_txn(8'h03, 8'h00, 8'h00, 0); read_txn("R1 cfg default", 1);

        // R2 upper bits ignored; R8 latch drives pin_out; R5 pointer kept
        write_txn(8'hFD, 8'h3C, 8'h00, 1);
        check("R8 pin_out", pin_out, 8'h3C);
        read_txn("R2 R5 ptr kept", 2);

        // R3 two bytes to config, last wins; no increment into other regs
        write_txn(8'h03, 8'hF0, 8'h0F, 2);
        check("R8 pin_oe", pin_oe, 8'hF0);
        read_txn("R3 cfg last byte", 3);
        write_txn(8'h02, 8'h00, 8'h00, 0);
        read_txn("R3 pol untouched", 1);

        // R7 driven high nibble reads back latch, low nibble external
        write_txn(8'h00, 8'h00, 8'h00, 0);
        read_txn("R7 loopback", 1);
        check("R7 model", model_read(), 8'h35);

        // R6 inversion on input reads
        write_txn(8'h02, 8'h81, 8'h00, 1);
        write_txn(8'h00, 8'h00, 8'h00, 0);
        read_txn("R6 inverted", 1);

        // R4 write to input view dropped
        write_txn(8'h80, 8'h00, 8'h55, 2);
        check("R4 pin_out", pin_out, 8'h3C);
        check("R4 pin_oe", pin_oe, 8'hF0);
        read_txn("R4 input unchanged", 1);
        write_txn(8'h02, 8'h00, 8'h00, 0);
        read_txn("R4 pol kept", 1);

        // R11 bytes outside a transfer ignored
        send_byte(8'h01); send_byte(8'h00); idle(2);
        check("R11 pin_out", pin_out, 8'h3C);
        check("R11 pin_oe", pin_oe, 8'hF0);
        read_txn("R11 ptr kept", 1);

        // R10 tx_req in a write transfer gives no tx_valid
        start_txn(1'b0);
        send_byte(8'h01);
        tx_req = 1'b1; @(negedge clk); tx_req = 1'b0;
        check("R10 no tx in write", {7'b0, tx_valid}, 8'h00);
        stop_txn(); idle(2);
        m_ptr = 2'd1;
        tx_req = 1'b1; @(negedge clk); tx_req = 1'b0;
        check("R10 no tx in idle", {7'b0, tx_valid}, 8'h00);

        // R9 read capture coinciding with final sync stage
        write_txn(8'h03, 8'hFF, 8'h00, 1);
        write_txn(8'h02, 8'h00, 8'h00, 1);
        write_txn(8'h00, 8'h00, 8'h00, 0);
        ext = 8'h00;
        idle(4);
        start_txn(1'b1);
        ext = 8'hFF;
        @(negedge clk);
        req_byte("R9 old level", 8'h00);
        req_byte("R9 new level", 8'hFF);
        idle(1);
        stop_txn();
        idle(3);

        check("R10 queue drained", 8'(exp_q.size()), 8'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule